// File: doc/BRIEF.md
# Lock-Guarded Device Configuration Registers

This block is a small memory-mapped register bank on a simple synchronous read/write bus. It holds one 32-bit device configuration register and a lock register that protects it. Software opens the lock by writing a fixed unlock code. That unlock is a one-shot: it permits exactly one write to the configuration register, and then the lock closes again. A later configuration write without a fresh unlock is dropped.

Three bits of the configuration register choose how three pin groups are routed. Each group (named E, G and H) is connected either to a disk-interface controller or to a general-purpose I/O port. The block contains the pin multiplexers for those groups. Output data and output enable come from the chosen side. Input data goes back to the chosen side only, and the other side sees zero.

The bus uses byte offsets; only the word bits are decoded. A read request is answered one cycle later with a valid strobe.

Top module: `cfglock_bank`

## Requirements
- R1: After reset the configuration register reads 0x0000_0000, the lock reads as closed, and all three pin groups are routed to the disk-interface side.
- R2: A write to the lock register (offset 0xC0) whose low byte is 0xAA opens the lock. A lock write with any other low byte leaves the lock closed, or closes it if it was open.
- R3: A read of the lock register returns 0x0000_0001 while the lock is open and 0x0000_0000 while it is closed.
- R4: A write to the configuration register (offset 0x80) while the lock is open stores all 32 data bits and closes the lock.
- R5: A write to the configuration register while the lock is closed leaves its contents unchanged.
- R6: A read of the configuration register returns the full stored value whether or not the lock is open. No read, of any offset, changes the lock state.
- R7: Writing 0xAA to the lock register while it is already open keeps it open for exactly one following configuration write, not two.
- R8: Configuration bit 8 selects group E, bit 10 selects group G and bit 11 selects group H. A value of 1 means general-purpose I/O and 0 means disk interface. The selects appear on `port_gpio_sel` as bit 0 = E, bit 1 = G, bit 2 = H.
- R9: For each group, `pad_out` and `pad_oe` come from the side its select picks, `pad_in` is copied to that side's input, and the other side's input reads zero. Group E uses pin bits [7:0], G uses [15:8] and H uses [23:16].
- R10: Reads of any offset other than 0x80 and 0xC0 return zero. Writes to such offsets change neither the configuration register nor the lock state.
- R11: Read data appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request is sampled. `bus_rvalid` is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| port_gpio_sel | output | 3 | Per-group route select, 1 = general-purpose I/O |
| ide_out | input | 24 | Disk-interface output data, all groups |
| ide_oe | input | 24 | Disk-interface output enables |
| ide_in | output | 24 | Pin input data steered to the disk interface |
| gpio_out | input | 24 | General-purpose output data, all groups |
| gpio_oe | input | 24 | General-purpose output enables |
| gpio_in | output | 24 | Pin input data steered to general-purpose I/O |
| pad_out | output | 24 | Pin output data |
| pad_oe | output | 24 | Pin output enables |
| pad_in | input | 24 | Pin input data |

## Verification
The bench checks that the unlock is consumed. A design that treated the lock as a level, or that counted two unlock writes as two credits, would accept the second configuration write after a single or doubled unlock. The bench also interleaves reads between the unlock and the guarded write, and it writes to unmapped offsets, including the unlock code at a neighbouring offset. A design that let either of those change the lock would show a wrong lock readback or a configuration value that should not have been stored. Finally, after each route change the pin outputs are compared slice by slice. This catches swapped select bit positions or input data leaking to the side that was not chosen.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned NPORT  = 3;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_CFG   = 2'd1,
        ACC_LOCK  = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_t;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              open;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

endpackage

// File: rtl/cfglock_decode.sv
module cfglock_decode
    import cfglock_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CFG_OFS  = 'h80,
    parameter int unsigned LOCK_OFS = 'hC0
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_kind_t         kind
);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

    always_comb begin
        if (!bus_sel) begin
            kind = ACC_NONE;
        end else if (bus_addr[ADDR_W-1:2] == CFG_A[ADDR_W-1:2]) begin
            kind = ACC_CFG;
        end else if (bus_addr[ADDR_W-1:2] == LOCK_A[ADDR_W-1:2]) begin
            kind = ACC_LOCK;
        end else begin
            kind = ACC_OTHER;
        end
    end
endmodule

// File: rtl/cfglock_regs.sv
module cfglock_regs
    import cfglock_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned UNLOCK_CODE = 'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  acc_kind_t         kind,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg_value
);
    localparam logic [CODE_W-1:0] CODE = CODE_W'(UNLOCK_CODE);

    regs_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        if (kind != ACC_NONE) begin
            if (bus_wr) begin
                case (kind)
                    ACC_LOCK: st_d.open = (bus_wdata[CODE_W-1:0] == CODE);
                    ACC_CFG: begin
                        if (st_q.open) begin
                            st_d.cfg = bus_wdata;
                        end
                        st_d.open = 1'b0;
                    end
                    default: ;
                endcase
            end else begin
                st_d.rvalid = 1'b1;
                case (kind)
                    ACC_CFG:  st_d.rdata = st_q.cfg;
                    ACC_LOCK: st_d.rdata = DATA_W'(st_q.open);
                    default:  st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.rdata;
    assign cfg_value  = st_q.cfg;

    logic cfg_wr, cfg_wr_ok, rd_req, other_wr;
    assign cfg_wr    = bus_wr && (kind == ACC_CFG);
    assign cfg_wr_ok = cfg_wr && st_q.open;
    assign rd_req    = !bus_wr && (kind != ACC_NONE);
    assign other_wr  = bus_wr && (kind == ACC_OTHER);

    // R4 R5
    property cfg_guarded_p;
        @(posedge clk) disable iff (!rst_n)
        (st_q.cfg != $past(st_q.cfg)) |-> $past(cfg_wr_ok);
    endproperty
    cfg_guarded_chk: assert property (cfg_guarded_p);

    // R4
    property lock_consumed_p;
        @(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !st_q.open;
    endproperty
    lock_consumed_chk: assert property (lock_consumed_p);

    // R6
    property read_keeps_lock_p;
        @(posedge clk) disable iff (!rst_n)
        rd_req |=> $stable(st_q.open);
    endproperty
    read_keeps_lock_chk: assert property (read_keeps_lock_p);

    // R10
    property unmapped_quiet_p;
        @(posedge clk) disable iff (!rst_n)
        other_wr |=> ($stable(st_q.open) && $stable(st_q.cfg));
    endproperty
    unmapped_quiet_chk: assert property (unmapped_quiet_p);

    // R11
    property rvalid_timing_p;
        @(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req);
    endproperty
    rvalid_timing_chk: assert property (rvalid_timing_p);

    // R3
    property lock_readback_p;
        @(posedge clk) disable iff (!rst_n)
        (rd_req && kind == ACC_LOCK) |=> (bus_rdata[DATA_W-1:1] == '0);
    endproperty
    lock_readback_chk: assert property (lock_readback_p);
endmodule

// File: rtl/cfglock_port_route.sv
module cfglock_port_route #(
    parameter int unsigned PIN_W = 8
) (
    input  logic             use_gpio,
    input  logic [PIN_W-1:0] ide_out,
    input  logic [PIN_W-1:0] ide_oe,
    input  logic [PIN_W-1:0] gpio_out,
    input  logic [PIN_W-1:0] gpio_oe,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] ide_in,
    output logic [PIN_W-1:0] gpio_in
);
    always_comb begin
        if (use_gpio) begin
            pad_out = gpio_out;
            pad_oe  = gpio_oe;
            gpio_in = pad_in;
            ide_in  = '0;
        end else begin
            pad_out = ide_out;
            pad_oe  = ide_oe;
            ide_in  = pad_in;
            gpio_in = '0;
        end
    end

    // R9
    always_comb begin
        route_excl_chk: assert (!((|ide_in) && (|gpio_in)));
    end
endmodule

// File: rtl/cfglock_bank.sv
module cfglock_bank
    import cfglock_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PIN_W       = 8,
    parameter int unsigned CFG_OFS     = 'h80,
    parameter int unsigned LOCK_OFS    = 'hC0,
    parameter int unsigned UNLOCK_CODE = 'hAA,
    parameter int unsigned SEL_BIT_E   = 8,
    parameter int unsigned SEL_BIT_G   = 10,
    parameter int unsigned SEL_BIT_H   = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_rvalid,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NPORT-1:0]        port_gpio_sel,
    input  logic [NPORT*PIN_W-1:0]  ide_out,
    input  logic [NPORT*PIN_W-1:0]  ide_oe,
    output logic [NPORT*PIN_W-1:0]  ide_in,
    input  logic [NPORT*PIN_W-1:0]  gpio_out,
    input  logic [NPORT*PIN_W-1:0]  gpio_oe,
    output logic [NPORT*PIN_W-1:0]  gpio_in,
    output logic [NPORT*PIN_W-1:0]  pad_out,
    output logic [NPORT*PIN_W-1:0]  pad_oe,
    input  logic [NPORT*PIN_W-1:0]  pad_in
);
    localparam int unsigned SEL_POS [NPORT] = '{SEL_BIT_E, SEL_BIT_G, SEL_BIT_H};

    acc_kind_t         kind;
    logic [DATA_W-1:0] cfg_value;

    cfglock_decode #(
        .ADDR_W  (ADDR_W),
        .CFG_OFS (CFG_OFS),
        .LOCK_OFS(LOCK_OFS)
    ) u_decode (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .kind    (kind)
    );

    cfglock_regs #(
        .CODE_W     (8),
        .UNLOCK_CODE(UNLOCK_CODE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .kind      (kind),
        .bus_wdata (bus_wdata),
        .bus_rvalid(bus_rvalid),
        .bus_rdata (bus_rdata),
        .cfg_value (cfg_value)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_gpio_sel[p] = cfg_value[SEL_POS[p]];

        cfglock_port_route #(
            .PIN_W(PIN_W)
        ) u_route (
            .use_gpio(port_gpio_sel[p]),
            .ide_out (ide_out [p*PIN_W +: PIN_W]),
            .ide_oe  (ide_oe  [p*PIN_W +: PIN_W]),
            .gpio_out(gpio_out[p*PIN_W +: PIN_W]),
            .gpio_oe (gpio_oe [p*PIN_W +: PIN_W]),
            .pad_in  (pad_in  [p*PIN_W +: PIN_W]),
            .pad_out (pad_out [p*PIN_W +: PIN_W]),
            .pad_oe  (pad_oe  [p*PIN_W +: PIN_W]),
            .ide_in  (ide_in  [p*PIN_W +: PIN_W]),
            .gpio_in (gpio_in [p*PIN_W +: PIN_W])
        );
    end

    // R8
    property sel_follows_cfg_p;
        @(posedge clk) disable iff (!rst_n)
        $stable(cfg_value) |-> $stable(port_gpio_sel);
    endproperty
    sel_follows_cfg_chk: assert property (sel_follows_cfg_p);
endmodule

// File: tb/cfglock_bank_test.sv
module cfglock_bank_test;
    localparam int PW = 8;
    localparam int NP = 3;
    localparam int VW = NP * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] port_gpio_sel;
    logic [VW-1:0] ide_out  = 24'hA1B2C3;
    logic [VW-1:0] ide_oe   = 24'h0F0F0F;
    logic [VW-1:0] gpio_out = 24'h5D6E7F;
    logic [VW-1:0] gpio_oe  = 24'hF0F0F0;
    logic [VW-1:0] pad_in   = 24'h123456;
    logic [VW-1:0] ide_in, gpio_in, pad_out, pad_oe;

    always #2.5 clk = ~clk;

    cfglock_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .port_gpio_sel(port_gpio_sel),
        .ide_out(ide_out), .ide_oe(ide_oe), .ide_in(ide_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] m_cfg = '0;
    bit          m_open = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle, model updated from the requirements.
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a[7:2] == 6'h30) begin
            m_open = (d[7:0] == 8'hAA);
        end else if (a[7:2] == 6'h20) begin
            if (m_open) m_cfg = d;
            m_open = 1'b0;
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        if (a[7:2] == 6'h20)      exp_q.push_back(m_cfg);
        else if (a[7:2] == 6'h30) exp_q.push_back({31'd0, m_open});
        else                      exp_q.push_back(32'd0);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Monitor: compares each returned read against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected rvalid", 32'd1, 32'd0);
                end else begin
                    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic check_ports(string tag);
        logic [2:0]    s;
        logic [VW-1:0] eo, eoe, eii, egi;
        @(negedge clk);
        s = {m_cfg[11], m_cfg[10], m_cfg[8]};
        for (int p = 0; p < NP; p++) begin
            eo [p*PW +: PW] = s[p] ? gpio_out[p*PW +: PW] : ide_out[p*PW +: PW];
            eoe[p*PW +: PW] = s[p] ? gpio_oe [p*PW +: PW] : ide_oe [p*PW +: PW];
            eii[p*PW +: PW] = s[p] ? '0 : pad_in[p*PW +: PW];
            egi[p*PW +: PW] = s[p] ? pad_in[p*PW +: PW] : '0;
        end
        chk({tag, " R8 select"},   32'(port_gpio_sel), 32'(s));
        chk({tag, " R9 pad_out"},  32'(pad_out), 32'(eo));
        chk({tag, " R9 pad_oe"},   32'(pad_oe),  32'(eoe));
        chk({tag, " R9 ide_in"},   32'(ide_in),  32'(eii));
        chk({tag, " R9 gpio_in"},  32'(gpio_in), 32'(egi));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 rvalid idle after reset", 32'(bus_rvalid), 32'd0);
        check_ports("R1 reset");
        bus_read(8'hC0, "R1 R3 lock closed after reset");
        bus_read(8'h80, "R1 cfg reset value");

        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_read(8'h80, "R5 write while locked ignored");

        bus_write(8'hC0, 32'h0000_0055);
        bus_read(8'hC0, "R2 wrong code keeps closed");
        bus_write(8'hC0, 32'h0000_00AA);
        bus_read(8'hC0, "R2 R3 code opens lock");
        bus_read(8'hC0, "R6 lock read does not consume");
        bus_read(8'h80, "R6 cfg read while open");

        bus_write(8'h40, 32'h0000_00AA);
        bus_read(8'hC0, "R10 unmapped write keeps lock");
        bus_read(8'h40, "R10 unmapped reads zero");

        bus_write(8'h80, 32'h0000_0800);
        bus_read(8'hC0, "R4 guarded write closes lock");
        bus_read(8'h80, "R4 guarded write stored");
        check_ports("R8 H only");

        bus_write(8'h80, 32'h0000_0100);
        bus_read(8'h80, "R5 second write without unlock");

        bus_write(8'hC0, 32'h0000_00AA);
        bus_write(8'hC0, 32'h0000_0000);
        bus_read(8'hC0, "R2 other value closes open lock");
        bus_write(8'h80, 32'h0000_0100);
        bus_read(8'h80, "R2 closed lock blocks write");

        bus_write(8'hC0, 32'h0000_00AA);
        bus_write(8'hC0, 32'h0000_00AA);
        bus_read(8'hC0, "R7 double unlock still open");
        bus_write(8'h80, 32'hDEAD_0D00);
        bus_read(8'hC0, "R7 closed after one write");
        bus_read(8'h80, "R7 first write stored");
        bus_write(8'h80, 32'h0000_0000);
        bus_read(8'h80, "R7 no second credit");
        check_ports("R8 all GPIO");

        bus_write(8'h44, 32'h0000_00AA);
        bus_read(8'hC0, "R10 code at unmapped offset");
        bus_write(8'hC0, 32'h0000_00AA);
        bus_write(8'h80, 32'h0000_0400);
        bus_read(8'h80, "R4 cfg G only");
        check_ports("R8 G only");

        repeat (3) @(negedge clk);
        chk("R11 all reads answered", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule